// File: doc/BRIEF.md
# Variable-Width IQ Sample Packer

The packer sits at the output of a multi-channel receive path. It takes one complex sample (an I and a Q component, each 16 bits) at a time and packs it into a 32-bit word at a quantization chosen at run time: 16, 8, 4, 2 or 1 bits per component. Each component is cut to the chosen width by keeping its most significant bits. Within a word, components are interleaved as I, Q, I, Q, starting at the least significant slot. A host can therefore unpack a word by walking from bit 0 upward. A run-time switch mirrors the slot order, so that the first sample lands in the top slot. This suits recording words straight to storage.

The block steps through the channels itself. The `chan_sel` output tells the upstream side which channel it must present next. The count rises from 0 to a programmable last channel and then returns to 0, and it carries on across word boundaries. A finished 32-bit word goes to the downstream 16-bit word buffer as two beats, low half first. Both sides use a valid/ready handshake.

Top module: `iq_sample_packer`

## Requirements
- R1: `cfg_width` selects the bits per component: code 0 gives 16, 1 gives 8, 2 gives 4, 3 gives 2 and 4 gives 1. At code 0 a word holds one sample, with I in bits 15:0 and Q in bits 31:16.
- R2: At code c a word holds 2^c samples. Counting slots from bit 0 upward, the k-th accepted sample of a word puts I in slot 2k and Q in slot 2k+1. Each slot is 16>>c bits wide and slot s starts at bit s*(16>>c).
- R3: A reduced-width slot holds the top (16>>c) bits of the 16-bit input component, with no rounding.
- R4: With `cfg_reverse` high, slot s holds what slot 2*2^c-1-s would hold with `cfg_reverse` low. The first I of a word therefore sits in the most significant slot, and its Q sits just below it.
- R5: `chan_sel` starts at 0 and rises by one for each accepted sample. After `cfg_chan_last` it returns to 0. The count continues across word boundaries.
- R6: Each completed word leaves as two `out_data` beats: bits 15:0 first, then bits 31:16.
- R7: `out_valid` rises only after a word's last slot has been filled. While `out_ready` is low, `out_valid` and `out_data` hold.
- R8: `in_ready` is low while a completed word has not been fully taken downstream.
- R9: A change on `cfg_width`, `cfg_reverse` or `cfg_chan_last` holds `in_ready` low for that cycle. It drops any partly filled word without output, and restarts the slot position and `chan_sel` at 0 under the new settings.
- R10: `cfg_width` codes 5, 6 and 7 behave like code 0.
- R11: Synchronous reset clears the slot position, the channel count and any partial word. After reset `out_valid` is low, `chan_sel` is 0, and `in_ready` is high while the configuration holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_width | input | 3 | Quantization code (R1, R10) |
| cfg_reverse | input | 1 | Mirror slot order within each word |
| cfg_chan_last | input | 3 | Index of the highest active channel (channel count minus one) |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample taken on this edge when valid |
| in_i | input | 16 | In-phase component of the offered sample |
| in_q | input | 16 | Quadrature component of the offered sample |
| chan_sel | output | 3 | Channel whose sample is taken next |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 16 | Output beat, low half of the word first |

## Verification
The bench uses the default parameters: 16-bit components, a 32-bit word split into two 16-bit beats, up to eight channels, and the reversal hardware present. These settings reach all five quantization widths in both slot orders, including the 1-bit case, where sixteen samples fill one word. They also reach the split of each word into two beats, and channel wrap with any active count up to eight. Holding `out_ready` low shows that input stalls behind a waiting word. A mid-word change of width shows that the partial word is dropped.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

   localparam int unsigned CODE_W = 3;

   typedef logic [CODE_W-1:0] wcode_t;

   // Codes above the highest legal one fall back to full width.
   function automatic wcode_t legal_code(input wcode_t raw, input wcode_t top);
      return (raw > top) ? '0 : raw;
   endfunction

endpackage

// File: rtl/iqp_chan_seq.sv
module iqp_chan_seq #(
   parameter int unsigned MAX_CH = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      restart,
   input  logic                      step,
   input  logic [$clog2(MAX_CH)-1:0] last,
   output logic [$clog2(MAX_CH)-1:0] chan
);

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         chan <= '0;
      end else if (step) begin
         chan <= (chan == last) ? '0 : chan + 1'b1;
      end
   end

   // R5: the count never passes the highest active channel
   a_r5_chan_in_range: assert property (@(posedge clk) disable iff (rst)
      !restart |=> chan <= $past(last));

endmodule

// File: rtl/iqp_slot_place.sv
module iqp_slot_place
   import iqp_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16,
   parameter bit          REV_EN   = 1'b1
) (
   input  wcode_t                         code,
   input  logic                           rev,
   input  logic [$clog2(SAMPLE_W)-1:0]    idx,
   input  logic [2*SAMPLE_W-1:0]          base,
   input  logic [SAMPLE_W-1:0]            comp_i,
   input  logic [SAMPLE_W-1:0]            comp_q,
   output logic [2*SAMPLE_W-1:0]          word,
   output logic                           last_idx
);

   localparam int unsigned WORD_W = 2 * SAMPLE_W;
   localparam int unsigned NCODE  = $clog2(SAMPLE_W) + 1;

   logic                          use_rev;
   logic [NCODE-1:0][WORD_W-1:0]  cand;

   generate
      if (REV_EN) begin : g_rev
         assign use_rev = rev;
      end else begin : g_norev
         assign use_rev = 1'b0;
      end
   endgenerate

   // One placement network per width; each has constant slot width.
   for (genvar c = 0; c < NCODE; c++) begin : g_code
      localparam int unsigned SW = SAMPLE_W >> c;
      localparam int unsigned NS = 1 << c;
      logic [WORD_W-1:0] w;

      always_comb begin
         int unsigned k;
         int unsigned si;
         int unsigned sq;
         k  = 32'(idx) % NS;
         si = use_rev ? (2*NS - 1 - 2*k) : (2*k);
         sq = use_rev ? (2*NS - 2 - 2*k) : (2*k + 1);
         w  = base;
         w[si*SW +: SW] = comp_i[SAMPLE_W-1 -: SW];
         w[sq*SW +: SW] = comp_q[SAMPLE_W-1 -: SW];
      end

      assign cand[c] = w;
   end

   assign word     = cand[code];
   assign last_idx = (32'(idx) == ((32'd1 << code) - 32'd1));

endmodule

// File: rtl/iqp_beat_out.sv
module iqp_beat_out #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned OUT_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   output logic              full,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OUT_W-1:0]  out_data
);

   localparam int unsigned BEATS = WORD_W / OUT_W;
   localparam int unsigned B_W   = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [B_W-1:0] LAST_BEAT = B_W'(BEATS - 1);

   logic [WORD_W-1:0] hold;
   logic [B_W-1:0]    beat;

   always_ff @(posedge clk) begin
      if (rst) begin
         full <= 1'b0;
         beat <= '0;
      end else if (load) begin
         hold <= word_in;
         full <= 1'b1;
         beat <= '0;
      end else if (full && out_ready) begin
         if (beat == LAST_BEAT) begin
            full <= 1'b0;
            beat <= '0;
         end else begin
            beat <= beat + 1'b1;
         end
      end
   end

   assign out_valid = full;
   assign out_data  = hold[32'(beat)*OUT_W +: OUT_W];

   // R7: a stalled beat holds still
   a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R6: after the top beat is taken the word is gone
   a_r6_done_after_top: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && beat == LAST_BEAT |=> !out_valid);

   // R8: no new word arrives on top of a pending one
   a_r8_no_load_when_full: assert property (@(posedge clk) disable iff (rst)
      load |-> !full);

endmodule

// File: rtl/iq_sample_packer.sv
module iq_sample_packer
   import iqp_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned OUT_W    = 16,
   parameter int unsigned MAX_CH   = 8,
   parameter bit          REV_EN   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [CODE_W-1:0]         cfg_width,
   input  logic                      cfg_reverse,
   input  logic [$clog2(MAX_CH)-1:0] cfg_chan_last,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [SAMPLE_W-1:0]       in_i,
   input  logic [SAMPLE_W-1:0]       in_q,
   output logic [$clog2(MAX_CH)-1:0] chan_sel,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [OUT_W-1:0]          out_data
);

   localparam int unsigned WORD_W   = 2 * SAMPLE_W;
   localparam int unsigned MAX_CODE = $clog2(SAMPLE_W);
   localparam int unsigned CH_W     = $clog2(MAX_CH);
   localparam int unsigned IDX_W    = $clog2(SAMPLE_W);

   generate
      if (SAMPLE_W < 2 || (SAMPLE_W & (SAMPLE_W - 1)) != 0) begin : g_bad_sample_w
         $error("SAMPLE_W must be a power of two of at least 2");
      end
      if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code_range
         $error("SAMPLE_W needs more width codes than CODE_W can hold");
      end
      if (OUT_W == 0 || (WORD_W % OUT_W) != 0) begin : g_bad_out_w
         $error("OUT_W must divide the packed word width");
      end
      if (MAX_CH < 2) begin : g_bad_max_ch
         $error("MAX_CH must be at least 2");
      end
   endgenerate

   wcode_t            cfg_code;
   wcode_t            act_code;
   logic              act_rev;
   logic [CH_W-1:0]   act_last;
   logic              cfg_same;
   logic [WORD_W-1:0] acc;
   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] placed;
   logic              last_idx;
   logic              hold_full;
   logic              accept;

   assign cfg_code = legal_code(cfg_width, CODE_W'(MAX_CODE));
   assign cfg_same = (cfg_code == act_code) && (cfg_reverse == act_rev)
                     && (cfg_chan_last == act_last);
   assign in_ready = cfg_same && !hold_full;
   assign accept   = in_valid && in_ready;

   iqp_slot_place #(
      .SAMPLE_W (SAMPLE_W),
      .REV_EN   (REV_EN)
   ) u_place (
      .code     (act_code),
      .rev      (act_rev),
      .idx      (idx),
      .base     ((idx == '0) ? '0 : acc),
      .comp_i   (in_i),
      .comp_q   (in_q),
      .word     (placed),
      .last_idx (last_idx)
   );

   always_ff @(posedge clk) begin
      if (rst || !cfg_same) begin
         act_code <= cfg_code;
         act_rev  <= cfg_reverse;
         act_last <= cfg_chan_last;
         idx      <= '0;
         acc      <= '0;
      end else if (accept) begin
         if (last_idx) begin
            idx <= '0;
            acc <= '0;
         end else begin
            idx <= idx + 1'b1;
            acc <= placed;
         end
      end
   end

   iqp_chan_seq #(
      .MAX_CH (MAX_CH)
   ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .restart (!cfg_same),
      .step    (accept),
      .last    (act_last),
      .chan    (chan_sel)
   );

   iqp_beat_out #(
      .WORD_W (WORD_W),
      .OUT_W  (OUT_W)
   ) u_out (
      .clk       (clk),
      .rst       (rst),
      .load      (accept && last_idx),
      .word_in   (placed),
      .full      (hold_full),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   // R5: each accepted sample moves the channel forward by one
   a_r5_chan_step: assert property (@(posedge clk) disable iff (rst)
      accept && chan_sel != act_last |=> chan_sel == $past(chan_sel) + 1'b1);

   // R9: a configuration change restarts the word and the channel count
   a_r9_restart: assert property (@(posedge clk) disable iff (rst)
      !cfg_same |=> chan_sel == '0 && idx == '0);

   // R7: output only follows an accepted sample that closed a word
   a_r7_word_from_input: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(accept));

endmodule

// File: tb/test_iq_sample_packer.sv
`timescale 1ns/1ps
module test_iq_sample_packer;

   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  cfg_width;
   logic        cfg_reverse;
   logic [2:0]  cfg_chan_last;
   logic        in_valid;
   logic        in_ready;
   logic [15:0] in_i;
   logic [15:0] in_q;
   logic [2:0]  chan_sel;
   logic        out_valid;
   logic        out_ready;
   logic [15:0] out_data;

   int          errors = 0;
   int          checks = 0;
   logic [15:0] got_q[$];
   bit          sink_hold = 1'b0;
   logic [15:0] iv[16];
   logic [15:0] qv[16];

   always #2.5 clk = ~clk;

   iq_sample_packer #(
      .SAMPLE_W (16),
      .OUT_W    (16),
      .MAX_CH   (8),
      .REV_EN   (1'b1)
   ) i_iq_sample_packer (
      .clk           (clk),
      .rst           (rst),
      .cfg_width     (cfg_width),
      .cfg_reverse   (cfg_reverse),
      .cfg_chan_last (cfg_chan_last),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .in_i          (in_i),
      .in_q          (in_q),
      .chan_sel      (chan_sel),
      .out_valid     (out_valid),
      .out_ready     (out_ready),
      .out_data      (out_data)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Downstream sink: drives ready and records taken beats at the falling edge.
   initial begin : sink
      out_ready = 1'b0;
      forever begin
         @(negedge clk);
         out_ready = !sink_hold;
         if (out_valid && out_ready) got_q.push_back(out_data);
      end
   end

   // Bit-by-bit reference word from the requirement text (R1-style layout).
   function automatic logic [31:0] ref_word(input int code, input bit rev);
      logic [31:0] w = '0;
      int sw = 16 >> code;
      int ns = 1 << code;
      for (int k = 0; k < ns; k++) begin
         for (int b = 0; b < sw; b++) begin
            int si = rev ? (2*ns - 1 - 2*k) : 2*k;
            int sq = rev ? (2*ns - 2 - 2*k) : 2*k + 1;
            w[si*sw + b] = iv[k][16 - sw + b];
            w[sq*sw + b] = qv[k][16 - sw + b];
         end
      end
      return w;
   endfunction

   task automatic push(input logic [15:0] i, input logic [15:0] q);
      in_i     = i;
      in_q     = q;
      in_valid = 1'b1;
      #1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_beats(input int n);
      while (got_q.size() < n) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [2:0] w, input bit rev, input logic [2:0] last);
      cfg_width     = w;
      cfg_reverse   = rev;
      cfg_chan_last = last;
      @(negedge clk);
   endtask

   // One full word: fill, push, compare both beats to the reference.
   task automatic run_word(input int code, input bit rev, input int seed, input string req);
      int ns = 1 << code;
      logic [31:0] exp;
      for (int k = 0; k < ns; k++) begin
         iv[k] = 16'(seed * 16'h03B5 + k * 16'h1D27 + 16'h8421);
         qv[k] = ~iv[k] ^ 16'(k * 16'h0F0F + seed);
      end
      for (int k = 0; k < ns; k++) push(iv[k], qv[k]);
      wait_beats(2);
      exp = ref_word(code, rev);
      check(got_q.size() == 2, {req, " beat count"}, 32'(got_q.size()), 32'd2);
      if (got_q.size() >= 2) begin
         check(got_q[0] == exp[15:0],  {req, " low beat"},  32'(got_q[0]), 32'(exp[15:0]));
         check(got_q[1] == exp[31:16], {req, " high beat"}, 32'(got_q[1]), 32'(exp[31:16]));
      end
      got_q.delete();
   endtask

   task automatic t_reset;
      // R11: idle state after synchronous reset
      check(out_valid == 1'b0, "R11 out_valid", 32'(out_valid), 32'd0);
      check(chan_sel == 3'd0,  "R11 chan_sel",  32'(chan_sel),  32'd0);
      check(in_ready == 1'b1,  "R11 in_ready",  32'(in_ready),  32'd1);
   endtask

   task automatic t_widths;
      set_cfg(3'd0, 1'b0, 3'd0);
      run_word(0, 1'b0, 1, "R1 16-bit");
      set_cfg(3'd1, 1'b0, 3'd0);
      run_word(1, 1'b0, 2, "R2 8-bit");
      set_cfg(3'd2, 1'b0, 3'd0);
      run_word(2, 1'b0, 3, "R3 4-bit truncation");
      set_cfg(3'd3, 1'b0, 3'd0);
      run_word(3, 1'b0, 4, "R2 2-bit");
      set_cfg(3'd4, 1'b0, 3'd0);
      run_word(4, 1'b0, 5, "R3 1-bit");
   endtask

   task automatic t_reverse;
      set_cfg(3'd1, 1'b1, 3'd0);
      run_word(1, 1'b1, 6, "R4 8-bit reversed");
      set_cfg(3'd3, 1'b1, 3'd0);
      run_word(3, 1'b1, 7, "R4 2-bit reversed");
      set_cfg(3'd0, 1'b1, 3'd0);
      run_word(0, 1'b1, 8, "R4 16-bit reversed");
   endtask

   task automatic t_channels;
      set_cfg(3'd1, 1'b0, 3'd2);
      for (int n = 0; n < 6; n++) begin
         check(chan_sel == 3'(n % 3), "R5 channel order", 32'(chan_sel), 32'(n % 3));
         push(16'(n * 16'h1111), 16'(n));
      end
      check(chan_sel == 3'd0, "R5 wrap after words", 32'(chan_sel), 32'd0);
      wait_beats(6);
      got_q.delete();
      set_cfg(3'd0, 1'b0, 3'd7);
      for (int n = 0; n < 9; n++) push(16'(n), 16'(n));
      check(chan_sel == 3'd1, "R5 eight-channel wrap", 32'(chan_sel), 32'd1);
      wait_beats(18);
      got_q.delete();
   endtask

   task automatic t_backpressure;
      logic [15:0] first;
      set_cfg(3'd0, 1'b0, 3'd0);
      sink_hold = 1'b1;
      @(negedge clk);
      push(16'hBEEF, 16'h1234);
      check(out_valid == 1'b1, "R7 valid after full word", 32'(out_valid), 32'd1);
      check(in_ready == 1'b0,  "R8 stall while word waits", 32'(in_ready), 32'd0);
      first = out_data;
      repeat (4) @(negedge clk);
      check(out_data == first && out_valid, "R7 held under stall", 32'(out_data), 32'(first));
      check(in_ready == 1'b0, "R8 still stalled", 32'(in_ready), 32'd0);
      sink_hold = 1'b0;
      wait_beats(2);
      check(got_q.size() == 2, "R6 beat count", 32'(got_q.size()), 32'd2);
      if (got_q.size() >= 2) begin
         check(got_q[0] == 16'hBEEF, "R6 low half first", 32'(got_q[0]), 32'hBEEF);
         check(got_q[1] == 16'h1234, "R6 high half second", 32'(got_q[1]), 32'h1234);
      end
      got_q.delete();
      check(in_ready == 1'b1, "R8 ready after drain", 32'(in_ready), 32'd1);
   endtask

   task automatic t_change;
      set_cfg(3'd2, 1'b0, 3'd7);
      push(16'hAAAA, 16'h5555);
      push(16'h7777, 16'h8888);
      cfg_width = 3'd1;
      #1;
      check(in_ready == 1'b0, "R9 ready low on change", 32'(in_ready), 32'd0);
      @(negedge clk);
      check(chan_sel == 3'd0, "R9 channel restart", 32'(chan_sel), 32'd0);
      check(got_q.size() == 0, "R9 partial word dropped", 32'(got_q.size()), 32'd0);
      run_word(1, 1'b0, 9, "R9 word after change");
   endtask

   task automatic t_illegal;
      set_cfg(3'd6, 1'b0, 3'd0);
      run_word(0, 1'b0, 10, "R10 code 6 as 16-bit");
      set_cfg(3'd5, 1'b0, 3'd0);
      run_word(0, 1'b0, 11, "R10 code 5 as 16-bit");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      rst           = 1'b1;
      cfg_width     = 3'd0;
      cfg_reverse   = 1'b0;
      cfg_chan_last = 3'd0;
      in_valid      = 1'b0;
      in_i          = '0;
      in_q          = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_widths();
      t_reverse();
      t_channels();
      t_backpressure();
      t_change();
      t_illegal();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule